// File: doc/BRIEF.md
# Merging Write Buffer with Read Bypass

This block sits between a cache and the memory bus and parks outgoing stores so the processor can keep running. Each slot holds one block address, one block of data and a byte-valid mask. A store to a block that already has a slot is folded into that slot: only the bytes the store enables are replaced. Slots are written back to memory one at a time, each as a single wide transfer that carries the block's byte-enable mask.

Loads use a lookup port. The load's block address is compared with every slot. If a slot holds every byte the load asks for, the data is returned from the buffer in the same cycle. If a slot holds only some of the requested bytes, that slot is written to memory first, ahead of any older slot, and the load then reads memory. A load that matches no slot takes the memory port before any pending write-back.

Top module: `wmerge_buf`

## Requirements
- R1: After reset the buffer is empty. No write transfer is requested, and a load goes straight to a memory read (`mem_req`=1, `mem_we`=0).
- R2: A store to a block that holds no slot takes a new slot. It later leaves as one write transfer with that block address, its data and its byte mask (bit i of `mem_be` covers bits 8i+7..8i of `mem_wdata`).
- R3: A store to a block that already holds a slot takes no new slot. Only its enabled bytes are overwritten, and the slot's mask becomes the OR of the old mask and the store's mask.
- R4: When every slot is occupied, a store that matches no slot is stalled (`st_stall`=1). A store that matches an occupied slot is accepted.
- R5: Slots are written back oldest first, with age set by the store that opened the slot. Merging does not change a slot's age.
- R6: A load whose requested bytes are all valid in a matching slot is acknowledged in the same cycle with `ld_fwd`=1 and the slot's data. No memory read is issued.
- R7: A load that matches no slot gets the memory port ahead of pending write-backs. It is acknowledged with `mem_rdata` in the cycle `mem_ready` is high.
- R8: A load that matches a slot holding only some of its bytes causes that slot to be written back first, even if it is not the oldest. The load then reads memory.
- R9: A store aimed at a slot that is being written back in the same cycle is stalled for that cycle. It then opens a fresh slot holding only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store present |
| st_blk | input | BLK_AW | Store block address |
| st_data | input | BYTES*8 | Store data, byte i at bits 8i+7..8i |
| st_be | input | BYTES | Store byte enables |
| st_stall | output | 1 | Store not taken this cycle |
| ld_valid | input | 1 | Load lookup present, held until acknowledged |
| ld_blk | input | BLK_AW | Load block address |
| ld_be | input | BYTES | Bytes the load needs |
| ld_ack | output | 1 | Load answered this cycle |
| ld_fwd | output | 1 | Answer comes from the buffer |
| ld_data | output | BYTES*8 | Load data |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = block write-back, 0 = read |
| mem_blk | output | BLK_AW | Transfer block address |
| mem_wdata | output | BYTES*8 | Write-back data |
| mem_be | output | BYTES | Byte enables of the transfer |
| mem_ready | input | 1 | Memory takes the transfer this cycle |
| mem_rdata | input | BYTES*8 | Read data, valid with `mem_ready` on a read |

## Verification
The hardest case to reach is a partial load hit on a slot that is not the oldest. From the ports, this needs an older slot that stays parked while a newer, partially filled slot exists. The bench holds `mem_ready` low while it builds that ordering. It then issues the load, checks that the newer slot is the one offered for write-back, and releases memory to watch the write-back go out before the read. The same-cycle store/write-back collision is reached by keeping memory always ready. A second store to a block is issued exactly one cycle after the first, which is the cycle its slot drains.

// File: rtl/wmb_pkg.sv
package wmb_pkg;
  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_READ  = 2'd1,
    PORT_DRAIN = 2'd2
  } port_own_e;
endpackage

// File: rtl/wbuf_cam.sv
module wbuf_cam #(
  parameter int DEPTH  = 4,
  parameter int BLK_AW = 12,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CW-1:0]                 occ,
  input  logic [DEPTH-1:0][BLK_AW-1:0]  blks,
  input  logic [BLK_AW-1:0]             key,
  output logic                          hit,
  output logic [IW-1:0]                 idx
);
  logic [DEPTH-1:0] match_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match_vec[g] = (CW'(g) < occ) && (blks[g] == key);
  end

  always_comb begin
    idx = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (match_vec[k]) idx = IW'(k);
    end
  end

  assign hit = |match_vec;

  // at most one slot per block, the consequence of merging
  assert_unique_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
endmodule

// File: rtl/wbuf_port_arb.sv
module wbuf_port_arb
  import wmb_pkg::*;
#(
  parameter int BLK_AW = 12,
  parameter int BYTES  = 8,
  localparam int DW = BYTES * 8
) (
  input  logic              rd_want,
  input  logic [BLK_AW-1:0] rd_blk,
  input  logic [BYTES-1:0]  rd_be,
  input  logic              wr_want,
  input  logic [BLK_AW-1:0] wr_blk,
  input  logic [DW-1:0]     wr_data,
  input  logic [BYTES-1:0]  wr_be,
  input  logic              mem_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BLK_AW-1:0] mem_blk,
  output logic [DW-1:0]     mem_wdata,
  output logic [BYTES-1:0]  mem_be,
  output logic              rd_go,
  output logic              wr_go
);
  port_own_e owner;

  always_comb begin
    if (rd_want)      owner = PORT_READ;
    else if (wr_want) owner = PORT_DRAIN;
    else              owner = PORT_IDLE;
  end

  always_comb begin
    mem_req   = (owner != PORT_IDLE);
    mem_we    = (owner == PORT_DRAIN);
    mem_blk   = (owner == PORT_READ) ? rd_blk : wr_blk;
    mem_be    = (owner == PORT_READ) ? rd_be  : wr_be;
    mem_wdata = (owner == PORT_DRAIN) ? wr_data : '0;
    rd_go     = (owner == PORT_READ)  && mem_ready;
    wr_go     = (owner == PORT_DRAIN) && mem_ready;
  end
endmodule

// File: rtl/wbuf_queue.sv
module wbuf_queue #(
  parameter int DEPTH  = 4,
  parameter int BLK_AW = 12,
  parameter int BYTES  = 8,
  localparam int DW = BYTES * 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          merge_en,
  input  logic [IW-1:0]                 merge_idx,
  input  logic                          ins_en,
  input  logic [BLK_AW-1:0]             in_blk,
  input  logic [DW-1:0]                 in_data,
  input  logic [BYTES-1:0]              in_be,
  input  logic                          drop_en,
  input  logic [IW-1:0]                 drop_idx,
  output logic [CW-1:0]                 q_cnt,
  output logic [DEPTH-1:0][BLK_AW-1:0]  q_blk,
  output logic [DEPTH-1:0][DW-1:0]      q_data,
  output logic [DEPTH-1:0][BYTES-1:0]   q_be
);
  logic [DEPTH-1:0][BLK_AW-1:0] n_blk;
  logic [DEPTH-1:0][DW-1:0]     n_data;
  logic [DEPTH-1:0][BYTES-1:0]  n_be;
  logic [CW-1:0]                n_cnt;
  logic [CW-1:0]                ins_slot;

  // replace only the enabled bytes of a block
  function automatic logic [DW-1:0] blend(input logic [DW-1:0] old_d,
                                          input logic [DW-1:0] new_d,
                                          input logic [BYTES-1:0] en);
    logic [DW-1:0] r;
    for (int b = 0; b < BYTES; b++)
      r[8*b +: 8] = en[b] ? new_d[8*b +: 8] : old_d[8*b +: 8];
    return r;
  endfunction

  always_comb begin
    n_blk  = q_blk;
    n_data = q_data;
    n_be   = q_be;
    // merge applies in place before any shift, so indices stay consistent
    if (merge_en) begin
      n_data[merge_idx] = blend(q_data[merge_idx], in_data, in_be);
      n_be[merge_idx]   = q_be[merge_idx] | in_be;
    end
    if (drop_en) begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        if (IW'(k) >= drop_idx) begin
          n_blk[k]  = n_blk[k+1];
          n_data[k] = n_data[k+1];
          n_be[k]   = n_be[k+1];
        end
      end
      n_be[DEPTH-1] = '0;
    end
    ins_slot = q_cnt - CW'(drop_en);
    if (ins_en) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (CW'(k) == ins_slot) begin
          n_blk[k]  = in_blk;
          n_data[k] = in_data;
          n_be[k]   = in_be;
        end
      end
    end
    n_cnt = q_cnt - CW'(drop_en) + CW'(ins_en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_cnt  <= '0;
      q_blk  <= '0;
      q_data <= '0;
      q_be   <= '0;
    end else begin
      q_cnt  <= n_cnt;
      q_blk  <= n_blk;
      q_data <= n_data;
      q_be   <= n_be;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CW'(DEPTH));

  assert_ins_has_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> (q_cnt < CW'(DEPTH)) || drop_en);

  assert_no_merge_into_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(merge_en && drop_en && (merge_idx == drop_idx)));

  assert_drop_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drop_en |-> (CW'(drop_idx) < q_cnt));
endmodule

// File: rtl/wmerge_buf.sv
module wmerge_buf #(
  parameter int DEPTH  = 4,
  parameter int BLK_AW = 12,
  parameter int BYTES  = 8,
  localparam int DW = BYTES * 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [BLK_AW-1:0] st_blk,
  input  logic [DW-1:0]     st_data,
  input  logic [BYTES-1:0]  st_be,
  output logic              st_stall,
  input  logic              ld_valid,
  input  logic [BLK_AW-1:0] ld_blk,
  input  logic [BYTES-1:0]  ld_be,
  output logic              ld_ack,
  output logic              ld_fwd,
  output logic [DW-1:0]     ld_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BLK_AW-1:0] mem_blk,
  output logic [DW-1:0]     mem_wdata,
  output logic [BYTES-1:0]  mem_be,
  input  logic              mem_ready,
  input  logic [DW-1:0]     mem_rdata
);
  logic [CW-1:0]                q_cnt;
  logic [DEPTH-1:0][BLK_AW-1:0] q_blk;
  logic [DEPTH-1:0][DW-1:0]     q_data;
  logic [DEPTH-1:0][BYTES-1:0]  q_be;

  logic          st_hit, ld_hit;
  logic [IW-1:0] st_idx, ld_idx, drain_idx;
  logic          ld_cover, fwd_now, ld_conflict, rd_want, wr_want;
  logic          rd_go, drain_fire;
  logic          st_hits_drain, st_full_miss, st_take, merge_en, ins_en;
  logic          buf_full;

  function automatic logic covers(input logic [BYTES-1:0] have,
                                  input logic [BYTES-1:0] need);
    return (have & need) == need;
  endfunction

  wbuf_cam #(.DEPTH(DEPTH), .BLK_AW(BLK_AW)) u_st_cam (
    .clk(clk), .rst_n(rst_n), .occ(q_cnt), .blks(q_blk), .key(st_blk),
    .hit(st_hit), .idx(st_idx));

  wbuf_cam #(.DEPTH(DEPTH), .BLK_AW(BLK_AW)) u_ld_cam (
    .clk(clk), .rst_n(rst_n), .occ(q_cnt), .blks(q_blk), .key(ld_blk),
    .hit(ld_hit), .idx(ld_idx));

  // load classification
  assign ld_cover    = covers(q_be[ld_idx], ld_be);
  assign fwd_now     = ld_valid && ld_hit && ld_cover;
  assign ld_conflict = ld_valid && ld_hit && !ld_cover;
  assign rd_want     = ld_valid && !ld_hit;
  assign wr_want     = (q_cnt != '0);
  assign drain_idx   = ld_conflict ? ld_idx : '0;
  assign buf_full    = (q_cnt == CW'(DEPTH));

  wbuf_port_arb #(.BLK_AW(BLK_AW), .BYTES(BYTES)) u_arb (
    .rd_want(rd_want), .rd_blk(ld_blk), .rd_be(ld_be),
    .wr_want(wr_want), .wr_blk(q_blk[drain_idx]), .wr_data(q_data[drain_idx]),
    .wr_be(q_be[drain_idx]), .mem_ready(mem_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_blk(mem_blk),
    .mem_wdata(mem_wdata), .mem_be(mem_be),
    .rd_go(rd_go), .wr_go(drain_fire));

  // store admission
  assign st_hits_drain = st_hit && drain_fire && (st_idx == drain_idx);
  assign st_full_miss  = !st_hit && buf_full;
  assign st_stall      = st_valid && (st_hits_drain || st_full_miss);
  assign st_take       = st_valid && !st_stall;
  assign merge_en      = st_take && st_hit;
  assign ins_en        = st_take && !st_hit;

  wbuf_queue #(.DEPTH(DEPTH), .BLK_AW(BLK_AW), .BYTES(BYTES)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .merge_en(merge_en), .merge_idx(st_idx),
    .ins_en(ins_en), .in_blk(st_blk), .in_data(st_data), .in_be(st_be),
    .drop_en(drain_fire), .drop_idx(drain_idx),
    .q_cnt(q_cnt), .q_blk(q_blk), .q_data(q_data), .q_be(q_be));

  // load answer
  assign ld_ack  = fwd_now || rd_go;
  assign ld_fwd  = fwd_now;
  assign ld_data = fwd_now ? q_data[ld_idx] : mem_rdata;

  assert_read_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_hit) |-> (mem_req && !mem_we && (mem_blk == ld_blk)));

  assert_fwd_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fwd |-> !(mem_req && !mem_we));

  assert_conflict_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_conflict |-> (mem_req && mem_we && (mem_blk == ld_blk)));

  assert_merge_keeps_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (merge_en && !drain_fire) |=> (q_cnt == $past(q_cnt)));

  assert_empty_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt == '0) |-> !(mem_req && mem_we));
endmodule

// File: tb/wmerge_buf_bench.sv
`timescale 1ns/100ps
module wmerge_buf_bench;
  localparam int DEPTH = 4;
  localparam int AW = 12;
  localparam int NB = 8;
  localparam int DW = NB * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          st_valid = 1'b0;
  logic [AW-1:0] st_blk = '0;
  logic [DW-1:0] st_data = '0;
  logic [NB-1:0] st_be = '0;
  logic          st_stall;
  logic          ld_valid = 1'b0;
  logic [AW-1:0] ld_blk = '0;
  logic [NB-1:0] ld_be = '0;
  logic          ld_ack, ld_fwd;
  logic [DW-1:0] ld_data;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_blk;
  logic [DW-1:0] mem_wdata;
  logic [NB-1:0] mem_be;
  logic          mem_ready = 1'b0;
  logic [DW-1:0] mem_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  function automatic logic [DW-1:0] rd_pat(input logic [AW-1:0] b);
    return {4{~b[7:0], b[7:0]}};
  endfunction
  assign mem_rdata = rd_pat(mem_blk);

  wmerge_buf #(.DEPTH(DEPTH), .BLK_AW(AW), .BYTES(NB)) u_wmerge_buf (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_blk(st_blk), .st_data(st_data), .st_be(st_be),
    .st_stall(st_stall),
    .ld_valid(ld_valid), .ld_blk(ld_blk), .ld_be(ld_be),
    .ld_ack(ld_ack), .ld_fwd(ld_fwd), .ld_data(ld_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_blk(mem_blk),
    .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata));

  // write-back log, taken just before each rising edge
  logic [AW-1:0] log_blk [0:15];
  logic [DW-1:0] log_data[0:15];
  logic [NB-1:0] log_be  [0:15];
  int log_n = 0;
  always begin
    @(negedge clk);
    #2;
    if (rst_n && mem_req && mem_we && mem_ready && log_n < 16) begin
      log_blk[log_n]  = mem_blk;
      log_data[log_n] = mem_wdata;
      log_be[log_n]   = mem_be;
      log_n++;
    end
  end

  function automatic logic [DW-1:0] mk(input logic [7:0] seed);
    logic [DW-1:0] r;
    for (int i = 0; i < NB; i++) r[8*i +: 8] = seed + 8'(i);
    return r;
  endfunction

  function automatic logic [DW-1:0] keep(input logic [DW-1:0] d, input logic [NB-1:0] be);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < NB; i++) if (be[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put_store(input logic [AW-1:0] b, input logic [DW-1:0] d, input logic [NB-1:0] be);
    @(negedge clk);
    st_valid = 1'b1; st_blk = b; st_data = d; st_be = be;
    #1;
    while (st_stall) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    mem_ready = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1;
    chk("R1 no request after reset", DW'(mem_req), 0);
    chk("R1 stall low after reset", DW'(st_stall), 0);
    ld_valid = 1'b1; ld_blk = 12'h123; ld_be = 8'hFF;
    #1;
    chk("R1 load goes to memory", DW'({mem_req, mem_we, ld_fwd}), DW'(3'b100));
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic t_merge_order();
    logic [DW-1:0] ea;
    mem_ready = 1'b0;
    log_n = 0;
    put_store(12'h010, mk(8'h10), 8'h0F);
    put_store(12'h020, mk(8'h20), 8'hFF);
    put_store(12'h010, mk(8'h90), 8'h31);
    put_store(12'h030, mk(8'h30), 8'h0F);
    flush();
    chk("R3 merge takes no slot (3 transfers)", DW'(log_n), 3);
    chk("R5 oldest first 0", DW'(log_blk[0]), 12'h010);
    chk("R5 merge keeps age 1", DW'(log_blk[1]), 12'h020);
    chk("R5 order 2", DW'(log_blk[2]), 12'h030);
    chk("R3 merged mask", DW'(log_be[0]), 8'h3F);
    ea = keep(mk(8'h10), 8'h0E) | keep(mk(8'h90), 8'h31);
    chk("R3 merged bytes", keep(log_data[0], 8'h3F), ea);
    chk("R2 whole block transfer", log_data[1], mk(8'h20));
    chk("R2 mask of new slot", DW'(log_be[2]), 8'h0F);
  endtask

  task automatic t_full();
    mem_ready = 1'b0;
    log_n = 0;
    for (int i = 0; i < DEPTH; i++) put_store(AW'(12'h100 + i), mk(8'(i)), 8'h01);
    @(negedge clk);
    st_valid = 1'b1; st_blk = 12'h1FF; st_data = mk(8'hAA); st_be = 8'hFF;
    #1;
    chk("R4 full and no match stalls", DW'(st_stall), 1);
    st_blk = 12'h101; st_be = 8'h02;
    #1;
    chk("R4 full but matching accepted", DW'(st_stall), 0);
    @(negedge clk);
    st_valid = 1'b0;
    flush();
    chk("R4 four transfers after full", DW'(log_n), 4);
    chk("R4 merged mask while full", DW'(log_be[1]), 8'h03);
  endtask

  task automatic t_forward();
    mem_ready = 1'b0;
    log_n = 0;
    put_store(12'h044, mk(8'h44), 8'hFF);
    @(negedge clk);
    ld_valid = 1'b1; ld_blk = 12'h044; ld_be = 8'h0F;
    #1;
    chk("R6 forward ack", DW'({ld_ack, ld_fwd}), DW'(2'b11));
    chk("R6 forward data", keep(ld_data, 8'h0F), keep(mk(8'h44), 8'h0F));
    chk("R6 no memory read", DW'(mem_req && !mem_we), 0);
    @(negedge clk);
    ld_valid = 1'b0;
    flush();
  endtask

  task automatic t_read_first();
    mem_ready = 1'b0;
    log_n = 0;
    put_store(12'h050, mk(8'h50), 8'hFF);
    @(negedge clk);
    ld_valid = 1'b1; ld_blk = 12'h060; ld_be = 8'hFF;
    #1;
    chk("R7 read owns port", DW'({mem_req, mem_we, ld_ack}), DW'(3'b100));
    chk("R7 read address", DW'(mem_blk), 12'h060);
    @(negedge clk);
    mem_ready = 1'b1;
    #1;
    chk("R7 read ack", DW'({ld_ack, ld_fwd}), DW'(2'b10));
    chk("R7 read data", ld_data, rd_pat(12'h060));
    @(negedge clk);
    ld_valid = 1'b0;
    chk("R7 write waited behind read", DW'(log_n), 0);
    repeat (4) @(negedge clk);
    chk("R7 write drained after read", DW'(log_n), 1);
  endtask

  task automatic t_partial();
    mem_ready = 1'b0;
    log_n = 0;
    put_store(12'h070, mk(8'h70), 8'h0F);
    put_store(12'h080, mk(8'h80), 8'h03);
    @(negedge clk);
    ld_valid = 1'b1; ld_blk = 12'h080; ld_be = 8'hFF;
    #1;
    chk("R8 partial hit drains matching slot", DW'({mem_req, mem_we, ld_ack}), DW'(3'b110));
    chk("R8 drained slot is the newer one", DW'(mem_blk), 12'h080);
    @(negedge clk);
    mem_ready = 1'b1;
    @(negedge clk);
    #1;
    chk("R8 then memory read", DW'({mem_we, ld_ack, ld_fwd}), DW'(3'b010));
    chk("R8 read data", ld_data, rd_pat(12'h080));
    @(negedge clk);
    ld_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 transfer count", DW'(log_n), 2);
    chk("R8 matching slot went first", DW'(log_blk[0]), 12'h080);
    chk("R8 older slot after", DW'(log_blk[1]), 12'h070);
  endtask

  task automatic t_collide();
    mem_ready = 1'b1;
    log_n = 0;
    @(negedge clk);
    st_valid = 1'b1; st_blk = 12'h090; st_data = mk(8'hC0); st_be = 8'h0F;
    #1;
    chk("R9 first store taken", DW'(st_stall), 0);
    @(negedge clk);
    st_data = mk(8'hD0); st_be = 8'hF0;
    #1;
    chk("R9 store stalled on draining slot", DW'(st_stall), 1);
    @(negedge clk);
    #1;
    chk("R9 store taken next cycle", DW'(st_stall), 0);
    @(negedge clk);
    st_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 two transfers", DW'(log_n), 2);
    chk("R9 first mask", DW'(log_be[0]), 8'h0F);
    chk("R9 second holds only own bytes", DW'(log_be[1]), 8'hF0);
    chk("R9 second data", keep(log_data[1], 8'hF0), keep(mk(8'hD0), 8'hF0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_merge_order();
    t_full();
    t_forward();
    t_read_first();
    t_partial();
    t_collide();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule